// File: doc/BRIEF.md
# Segment Limit Loader

This block carries out a load-segment-limit operation for a protected-mode core. A request names a 16-bit segment selector and gives the current privilege level, an operand-size flag, and the base and limit of the global and local descriptor tables. The block first makes the checks that need only the selector and the chosen table's limit. If those pass, it reads the 8-byte descriptor through a synchronous 64-bit read port. It then checks the descriptor's type and privilege.

On success it rebuilds the 20-bit limit, which is split across the descriptor, and expands it to a 32-bit byte limit. It raises the zero flag and gives write enables for the destination register. On any failure it clears the flag and asserts no write enable. A one-cycle `start` opens an operation, and a one-cycle `done` closes it.

Top module: `seglim_loader`

## Requirements
- R1: The raw 20-bit limit takes bits 15:0 from descriptor bytes 0–1 (`rd_data[15:0]`) and bits 19:16 from the low nibble of byte 6 (`rd_data[51:48]`). Byte n of the descriptor is `rd_data[8n+7:8n]`.
- R2: When the granularity bit (`rd_data[55]`) is 0, the byte limit is the raw limit zero-extended to 32 bits.
- R3: When the granularity bit is 1, the byte limit is the raw limit shifted left by 12, with bits 11:0 set to one.
- R4: With `opsize32` = 1, a successful operation asserts `dest_we` = 2'b11 (both halves of `dest_data`).
- R5: With `opsize32` = 0, a successful operation still presents the full 32-bit limit on `dest_data` but asserts only `dest_we` = 2'b01 (low half).
- R6: A selector whose index (bits 15:3) and table bit (bit 2) are both zero is null. It fails without any descriptor read, and `done` rises one cycle after `start`.
- R7: The table bit selects the local table (1) or the global table (0). The descriptor is read at table base + index×8. If index×8+7 exceeds the selected table limit, the operation fails without a read.
- R8: Descriptors with the S bit (`rd_data[44]`) set are valid for any type. With S clear, only types (`rd_data[43:40]`) 1, 2, 3, 9 and 11 are valid. All other system types fail.
- R9: Unless the segment is conforming code, the operation fails when either the privilege level `cpl` or the selector's RPL (bits 1:0) is numerically greater than the DPL (`rd_data[46:45]`).
- R10: A conforming code segment (S = 1, type bit 3 = 1 and type bit 2 = 1) skips the privilege check.
- R11: On failure `zf` = 0 and `dest_we` = 0. On success `zf` = 1. `zf` holds until the next `done`.
- R12: After reset, `done`, `zf`, `dest_we` and `rd_en` are 0. `done` is a one-cycle pulse. When a read is issued with `start`, `done` rises two cycles after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| selector | input | 16 | Segment selector |
| cpl | input | 2 | Current privilege level |
| opsize32 | input | 1 | 1: 32-bit destination, 0: 16-bit |
| gdt_base | input | AW | Global table base address |
| gdt_limit | input | TLW | Global table limit (last valid byte offset) |
| ldt_base | input | AW | Local table base address |
| ldt_limit | input | TLW | Local table limit |
| rd_en | output | 1 | Descriptor read request |
| rd_addr | output | AW | Descriptor byte address |
| rd_data | input | 64 | Descriptor, valid the cycle after `rd_en` |
| done | output | 1 | Operation complete pulse |
| zf | output | 1 | Zero flag result |
| dest_we | output | 2 | Destination write enables: bit 0 low half, bit 1 high half |
| dest_data | output | 32 | Expanded byte limit |

## Verification
The bench builds the block with AW = 20 and TLW = 12. With a 12-bit table limit, the bound check can be swept over every index, up to and past a table's end, for both tables.

A full sweep covers these fields together:
- the S bit and all 16 types
- every DPL
- every privilege level
- every RPL

This reaches each type rule, the privilege rule and the conforming-code exception in every combination. A separate sweep covers both granularities and both operand sizes over a set of limit patterns, including all-zero and all-one limits.

// File: rtl/seglim_loader.sv
module seglim_loader #(
  parameter int AW  = 32,
  parameter int TLW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [15:0]    selector,
  input  logic [1:0]     cpl,
  input  logic           opsize32,
  input  logic [AW-1:0]  gdt_base,
  input  logic [TLW-1:0] gdt_limit,
  input  logic [AW-1:0]  ldt_base,
  input  logic [TLW-1:0] ldt_limit,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  input  logic [63:0]    rd_data,
  output logic           done,
  output logic           zf,
  output logic [1:0]     dest_we,
  output logic [31:0]    dest_data
);
  localparam int CW = ((TLW > 16) ? TLW : 16) + 1;

  typedef enum logic {ST_IDLE, ST_EVAL} st_t;
  st_t st;

  logic [1:0] rpl_q, cpl_q;
  logic       wide_q;

  wire [12:0]    idx      = selector[15:3];
  wire           use_ldt  = selector[2];
  wire           is_null  = (idx == 13'd0) && !use_ldt;
  wire [TLW-1:0] tbl_lim  = use_ldt ? ldt_limit : gdt_limit;
  wire [CW-1:0]  last_off = CW'({idx, 3'b111});
  wire           in_bound = last_off <= CW'(tbl_lim);
  wire           pre_ok   = !is_null && in_bound;

  assign rd_en   = (st == ST_IDLE) && start && pre_ok;
  assign rd_addr = (use_ldt ? ldt_base : gdt_base) + AW'({idx, 3'b000});

  wire [3:0]  d_type  = rd_data[43:40];
  wire        d_s     = rd_data[44];
  wire [1:0]  d_dpl   = rd_data[46:45];
  wire        d_gran  = rd_data[55];
  wire [19:0] raw_lim = {rd_data[51:48], rd_data[15:0]};
  wire [31:0] lim32   = d_gran ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};

  logic sys_ok;
  always_comb begin
    case (d_type)
      4'd1, 4'd2, 4'd3, 4'd9, 4'd11: sys_ok = 1'b1;
      default:                       sys_ok = 1'b0;
    endcase
  end

  wire type_ok = d_s || sys_ok;
  wire conform = d_s && d_type[3] && d_type[2];
  wire priv_ok = conform || ((cpl_q <= d_dpl) && (rpl_q <= d_dpl));
  wire desc_ok = type_ok && priv_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      done      <= 1'b0;
      zf        <= 1'b0;
      dest_we   <= 2'b00;
      dest_data <= 32'd0;
      rpl_q     <= 2'd0;
      cpl_q     <= 2'd0;
      wide_q    <= 1'b0;
    end else begin
      done    <= 1'b0;
      dest_we <= 2'b00;
      case (st)
        ST_IDLE: if (start) begin
          rpl_q  <= selector[1:0];
          cpl_q  <= cpl;
          wide_q <= opsize32;
          if (pre_ok) begin
            st <= ST_EVAL;
          end else begin
            done <= 1'b1;
            zf   <= 1'b0;
          end
        end
        ST_EVAL: begin
          st   <= ST_IDLE;
          done <= 1'b1;
          zf   <= desc_ok;
          if (desc_ok) begin
            dest_we   <= wide_q ? 2'b11 : 2'b01;
            dest_data <= lim32;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seglim_loader_chk.sv
module seglim_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] selector,
  input logic        rd_en,
  input logic        done,
  input logic        zf,
  input logic [1:0]  dest_we,
  input logic [31:0] dest_data
);
  AST_PAGE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zf && dest_data[31:20] != 12'd0) |-> dest_data[11:0] == 12'hFFF); // R3

  AST_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_we != 2'b00) |-> dest_we[0]); // R5

  AST_NULL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (selector[15:2] != 14'd0)); // R6

  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !zf) |-> dest_we == 2'b00); // R11

  AST_WE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_we != 2'b00) |-> (done && zf)); // R11

  AST_READ_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (!done ##1 done)); // R12
endmodule

bind seglim_loader seglim_loader_chk u_chk (.*);

// File: tb/test_seglim_loader.sv
module test_seglim_loader;
  localparam int CLK_P = 10;
  localparam int AW = 20;
  localparam int TLW = 12;

  logic clk = 0, rst_n = 0, start = 0, opsize32 = 0;
  logic [15:0] selector = 0;
  logic [1:0] cpl = 0;
  logic [AW-1:0] gdt_base = 0, ldt_base = 0;
  logic [TLW-1:0] gdt_limit = 0, ldt_limit = 0;
  logic rd_en, done, zf;
  logic [AW-1:0] rd_addr;
  logic [63:0] rd_data = 0, desc_word = 0;
  logic [1:0] dest_we;
  logic [31:0] dest_data;
  int reads = 0;
  logic [AW-1:0] last_addr = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  seglim_loader #(.AW(AW), .TLW(TLW)) i_seglim_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .selector(selector), .cpl(cpl),
    .opsize32(opsize32), .gdt_base(gdt_base), .gdt_limit(gdt_limit),
    .ldt_base(ldt_base), .ldt_limit(ldt_limit), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .zf(zf), .dest_we(dest_we), .dest_data(dest_data));

  always @(posedge clk) if (rd_en) begin
    rd_data   <= desc_word;
    reads     <= reads + 1;
    last_addr <= rd_addr;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_desc(input bit g, input logic [19:0] raw,
      input logic [1:0] dpl, input bit s, input logic [3:0] t);
    return {8'h00, g, 3'b000, raw[19:16], 1'b1, dpl, s, t, 24'h000000, raw[15:0]};
  endfunction

  function automatic bit exp_pre(input logic [15:0] sel);
    logic [16:0] last;
    logic [TLW-1:0] lim;
    if (sel[15:3] == 0 && !sel[2]) return 0;
    last = {1'b0, sel[15:3], 3'b111};
    lim = sel[2] ? ldt_limit : gdt_limit;
    return last <= 17'(lim);
  endfunction

  function automatic bit exp_desc(input logic [15:0] sel, input logic [1:0] c,
                                  input logic [63:0] d);
    logic [3:0] t = d[43:40];
    logic [1:0] dpl = d[46:45];
    bit s = d[44];
    if (!s && !(t == 1 || t == 2 || t == 3 || t == 9 || t == 11)) return 0;
    if (s && t[3] && t[2]) return 1;
    return (c <= dpl) && (sel[1:0] <= dpl);
  endfunction

  task automatic run(input logic [15:0] sel, input logic [1:0] c, input bit wide,
                     input logic [63:0] d, input string req);
    int lat, r0;
    bit pre, ok;
    logic [19:0] raw;
    logic [31:0] elim;
    @(negedge clk);
    selector = sel; cpl = c; opsize32 = wide; desc_word = d; start = 1; r0 = reads;
    pre = exp_pre(sel);
    ok = pre && exp_desc(sel, c, d);
    @(negedge clk);
    start = 0; lat = 1;
    while (!done && lat < 6) begin @(negedge clk); lat++; end
    chk(done == 1, "R12", "done", 64'(done), 64'd1);
    chk(lat == (pre ? 2 : 1), pre ? "R12" : "R6", "latency", 64'(lat), 64'(pre ? 2 : 1));
    chk(reads - r0 == (pre ? 1 : 0), pre ? "R7" : "R6", "reads", 64'(reads - r0), 64'(pre ? 1 : 0));
    if (pre) begin
      logic [AW-1:0] ea = (sel[2] ? ldt_base : gdt_base) + AW'({sel[15:3], 3'b000});
      chk(last_addr == ea, "R7", "address", 64'(last_addr), 64'(ea));
    end
    chk(zf == ok, req, "zf", 64'(zf), 64'(ok));
    chk(dest_we == (ok ? (wide ? 2'b11 : 2'b01) : 2'b00), ok ? (wide ? "R4" : "R5") : "R11",
        "dest_we", 64'(dest_we), 64'(ok ? (wide ? 2'b11 : 2'b01) : 2'b00));
    if (ok) begin
      raw = {d[51:48], d[15:0]};
      elim = d[55] ? {raw, 12'hFFF} : {12'h000, raw};
      chk(dest_data == elim, d[55] ? "R3" : "R2", "limit", 64'(dest_data), 64'(elim));
    end
    @(negedge clk);
    chk(done == 0, "R12", "done pulse", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0 && zf == 0 && dest_we == 0 && rd_en == 0, "R12", "reset outputs",
        {59'd0, done, zf, dest_we, rd_en}, 64'd0);
    rst_n = 1;
    gdt_base = 20'h1_0000; gdt_limit = 12'hFFF;
    ldt_base = 20'h4_8000; ldt_limit = 12'h0FF;

    for (int s = 0; s < 2; s++)
      for (int t = 0; t < 16; t++)
        for (int dpl = 0; dpl < 4; dpl++)
          for (int c = 0; c < 4; c++)
            for (int rpl = 0; rpl < 4; rpl++) begin
              string req;
              if (s == 0) req = "R8";
              else if (t[3] && t[2]) req = "R10";
              else req = "R9";
              run({13'd5, 1'b0, 2'(rpl)}, 2'(c), 1,
                  mk_desc(0, 20'h5_1234, 2'(dpl), 1'(s), 4'(t)), req);
            end

    for (int g = 0; g < 2; g++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 12; k++) begin
          logic [19:0] raw;
          raw = (k == 0) ? 20'h0 : (k == 1) ? 20'hFFFFF : (k == 2) ? 20'h80000 :
                20'(k * 32'h1_3579 ^ 32'h0_A5C3);
          run({13'd9, 1'b1, 2'd0}, 2'd0, 1'(w), mk_desc(1'(g), raw, 2'd3, 1, 4'h2), "R1");
        end

    gdt_limit = 12'h07F;
    for (int i = 0; i < 20; i++)
      run({13'(i), 1'b0, 2'd3}, 2'd3, 1, mk_desc(0, 20'h0_0ABC, 2'd3, 1, 4'hA),
          i == 0 ? "R6" : "R7");
    ldt_limit = 12'h0FE;
    for (int i = 0; i < 40; i++)
      run({13'(i), 1'b1, 2'd0}, 2'd0, 0, mk_desc(1, 20'h0_0012, 2'd0, 0, 4'h9), "R7");
    ldt_limit = 12'hFFF;
    for (int i = 500; i < 512; i++)
      run({13'(i), 1'b1, 2'd0}, 2'd1, 1, mk_desc(0, 20'h1_0001, 2'd1, 0, 4'h3), "R7");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule